// File: doc/BRIEF.md
# Lookahead Lock Tracker

This block keeps the dependence state for a group of hardware instruction streams that share one issue slot. Every stream has a ring of eight small countdown counters (locks) and a pointer to the lock of its next instruction. A stream reports ready when the lock under its pointer reads zero. The issue logic outside this block picks one ready stream and presents its stream number, its 3-bit lookahead value and whether the instruction carries a memory operation.

On an issue, the tracker raises the lock of the instruction that lookahead plus one places after the current one. It returns that lock index to the requester and moves the stream pointer forward. The lock index comes back later with the completion so that it can be lowered again. An instruction without a memory operation completes after a fixed pipeline delay, and an internal delay line produces that completion. A memory instruction completes when its response arrives on the completion port. Up to eight instructions of one stream can be in flight at once.

Top module: `lookahead_lock_tracker`

## Requirements
- R1: After reset every lock is zero and every stream pointer is zero. All `ready` bits are 1, and `iss_wait_idx` for lookahead 0 reads 1 for any stream.
- R2: `iss_wait_idx` is, combinationally, (pointer of `iss_stream` + `iss_lookahead` + 1) mod 8.
- R3: An issue (legal only while that stream is ready) adds one to the lock at `iss_wait_idx` and advances the stream pointer by one mod 8. `ready[s]` is 1 exactly when the lock under stream s's pointer is zero.
- R4: With lookahead 0 the stream is not ready in the cycle after the issue. With lookahead 7 the stream stays ready through 8 issues in a row and stalls only after the eighth.
- R5: An instruction with `iss_has_mem`=0 has its lock lowered at the PIPE_DELAY-th rising edge after its issue edge, with no outside event.
- R6: A memory completion (`mem_cpl_valid`, stream, lock index) lowers that lock by one. A memory instruction's lock is never lowered by the fixed-delay path.
- R7: An increment and one or two decrements that hit the same lock at the same edge combine to their net sum, so an increment with one decrement leaves it unchanged.
- R8: Issues and completions on one stream leave every other stream's locks and `ready` unchanged.
- R9: A lock counts up to 8 pending predecessors without wrapping. The waiting instruction stays blocked until every one of them has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_stream | input | SW | Stream of the issuing instruction |
| iss_lookahead | input | 3 | Lookahead value of the issuing instruction |
| iss_has_mem | input | 1 | 1: completes on a memory response; 0: completes after PIPE_DELAY |
| iss_wait_idx | output | 3 | Lock index raised by this issue, to be returned at completion |
| mem_cpl_valid | input | 1 | A memory instruction completes this cycle |
| mem_cpl_stream | input | SW | Stream of the completing instruction |
| mem_cpl_idx | input | 3 | Lock index to lower |
| ready | output | NUM_STREAMS | Per-stream issue permission |

## Verification
The assertions take for granted that the issue logic presents an issue only for a stream whose ready bit is set. They also take for granted that a memory completion names a lock that is currently nonzero, so that no counter is lowered below zero by a stray response. The stimulus keeps within both rules. Each directed task keeps its own model of every stream's pointer and issues only to streams that model shows ready. A memory completion returns only a lock index that an earlier memory issue produced, once per issue. The tasks wait for the fixed-delay completions to drain before the next scenario starts.

// File: rtl/lat_pkg.sv
package lat_pkg;
    localparam int LA_W      = 3;
    localparam int NUM_LOCKS = 1 << LA_W;
    localparam int CNT_W     = LA_W + 1;
    localparam logic [CNT_W-1:0] LOCK_MAX = CNT_W'(NUM_LOCKS);
    localparam logic [LA_W-1:0]  SLOT_ONE = LA_W'(1);

    // lock index of the instruction that must wait for the one at ptr
    function automatic logic [LA_W-1:0] wait_slot(input logic [LA_W-1:0] ptr,
                                                  input logic [LA_W-1:0] la);
        return ptr + la + SLOT_ONE;
    endfunction
endpackage

// File: rtl/lat_lock_ring.sv
module lat_lock_ring
    import lat_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc_en,
    input  logic [LA_W-1:0]            inc_idx,
    input  logic                       dec_a_en,
    input  logic [LA_W-1:0]            dec_a_idx,
    input  logic                       dec_b_en,
    input  logic [LA_W-1:0]            dec_b_idx,
    output logic                       ready,
    output logic [LA_W-1:0]            ptr_q,
    output logic [NUM_LOCKS*CNT_W-1:0] locks_flat
);
    logic [CNT_W-1:0] lock_q [NUM_LOCKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (inc_en) begin
            ptr_q <= ptr_q + SLOT_ONE;
        end
    end

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        logic inc_hit, a_hit, b_hit;
        logic [CNT_W-1:0] lock_d;

        always_comb begin
            inc_hit = inc_en   && (inc_idx   == LA_W'(g));
            a_hit   = dec_a_en && (dec_a_idx == LA_W'(g));
            b_hit   = dec_b_en && (dec_b_idx == LA_W'(g));
            lock_d  = lock_q[g]
                    + {{(CNT_W-1){1'b0}}, inc_hit}
                    - {{(CNT_W-1){1'b0}}, a_hit}
                    - {{(CNT_W-1){1'b0}}, b_hit};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[g] <= '0;
            end else begin
                lock_q[g] <= lock_d;
            end
        end

        assign locks_flat[g*CNT_W +: CNT_W] = lock_q[g];
    end

    assign ready = (lock_q[ptr_q] == '0);
endmodule

// File: rtl/lat_fixed_delay.sv
module lat_fixed_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         vld_q [DEPTH];
    logic [W-1:0] dat_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic         vld_in;
        logic [W-1:0] dat_in;
        if (k == 0) begin : g_head
            assign vld_in = in_valid;
            assign dat_in = in_data;
        end else begin : g_body
            assign vld_in = vld_q[k-1];
            assign dat_in = dat_q[k-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[k] <= 1'b0;
                dat_q[k] <= '0;
            end else begin
                vld_q[k] <= vld_in;
                dat_q[k] <= dat_in;
            end
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_data  = dat_q[DEPTH-1];
endmodule

// File: rtl/lookahead_lock_tracker.sv
module lookahead_lock_tracker
    import lat_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int PIPE_DELAY  = 4,
    localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid,
    input  logic [SW-1:0]          iss_stream,
    input  logic [LA_W-1:0]        iss_lookahead,
    input  logic                   iss_has_mem,
    output logic [LA_W-1:0]        iss_wait_idx,
    input  logic                   mem_cpl_valid,
    input  logic [SW-1:0]          mem_cpl_stream,
    input  logic [LA_W-1:0]        mem_cpl_idx,
    output logic [NUM_STREAMS-1:0] ready
);
    localparam int PW = SW + LA_W;

    logic [LA_W-1:0]  ptr_all [NUM_STREAMS];
    logic [NUM_STREAMS*NUM_LOCKS*CNT_W-1:0] lock_flat;

    logic             pipe_out_valid;
    logic [PW-1:0]    pipe_out_data;
    logic [SW-1:0]    pipe_stream;
    logic [LA_W-1:0]  pipe_idx;

    assign iss_wait_idx = wait_slot(ptr_all[iss_stream], iss_lookahead);

    lat_fixed_delay #(
        .DEPTH (PIPE_DELAY),
        .W     (PW)
    ) u_fixed_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (iss_valid && !iss_has_mem),
        .in_data   ({iss_stream, iss_wait_idx}),
        .out_valid (pipe_out_valid),
        .out_data  (pipe_out_data)
    );

    assign {pipe_stream, pipe_idx} = pipe_out_data;

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        lat_lock_ring u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_en     (iss_valid && (iss_stream == SW'(s))),
            .inc_idx    (iss_wait_idx),
            .dec_a_en   (mem_cpl_valid && (mem_cpl_stream == SW'(s))),
            .dec_a_idx  (mem_cpl_idx),
            .dec_b_en   (pipe_out_valid && (pipe_stream == SW'(s))),
            .dec_b_idx  (pipe_idx),
            .ready      (ready[s]),
            .ptr_q      (ptr_all[s]),
            .locks_flat (lock_flat[s*NUM_LOCKS*CNT_W +: NUM_LOCKS*CNT_W])
        );
    end
endmodule

// File: rtl/lat_checker.sv
module lat_checker
    import lat_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int SW          = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   iss_valid,
    input logic [SW-1:0]          iss_stream,
    input logic [LA_W-1:0]        iss_lookahead,
    input logic                   mem_cpl_valid,
    input logic [SW-1:0]          mem_cpl_stream,
    input logic [LA_W-1:0]        mem_cpl_idx,
    input logic                   pipe_out_valid,
    input logic [NUM_STREAMS-1:0] ready,
    input logic [NUM_STREAMS*NUM_LOCKS*CNT_W-1:0] lock_flat
);
    logic [CNT_W-1:0] cpl_lock;
    assign cpl_lock = lock_flat[(int'(mem_cpl_stream)*NUM_LOCKS + int'(mem_cpl_idx))*CNT_W +: CNT_W];

    p_issue_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ready[iss_stream]);

    p_cpl_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cpl_valid |-> (cpl_lock != '0));

    p_stall_after_l0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_lookahead == '0) |=> !ready[$past(iss_stream)]);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_str
        p_other_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_stream != SW'(s) && !mem_cpl_valid && !pipe_out_valid)
            |=> $stable(ready[s]));
    end

    for (genvar i = 0; i < NUM_STREAMS*NUM_LOCKS; i++) begin : g_lk
        p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            lock_flat[i*CNT_W +: CNT_W] <= LOCK_MAX);
        p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_flat[i*CNT_W +: CNT_W] == '0) |=> (lock_flat[i*CNT_W +: CNT_W] <= CNT_W'(1)));
    end
endmodule

bind lookahead_lock_tracker lat_checker #(
    .NUM_STREAMS (NUM_STREAMS),
    .SW          (SW)
) u_lat_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid      (iss_valid),
    .iss_stream     (iss_stream),
    .iss_lookahead  (iss_lookahead),
    .mem_cpl_valid  (mem_cpl_valid),
    .mem_cpl_stream (mem_cpl_stream),
    .mem_cpl_idx    (mem_cpl_idx),
    .pipe_out_valid (pipe_out_valid),
    .ready          (ready),
    .lock_flat      (lock_flat)
);

// File: tb/test_lookahead_lock_tracker.sv
module test_lookahead_lock_tracker;
    localparam int NS  = 4;
    localparam int DLY = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          iss_valid;
    logic [1:0]    iss_stream;
    logic [2:0]    iss_lookahead;
    logic          iss_has_mem;
    logic [2:0]    iss_wait_idx;
    logic          mem_cpl_valid;
    logic [1:0]    mem_cpl_stream;
    logic [2:0]    mem_cpl_idx;
    logic [NS-1:0] ready;

    int checks = 0;
    int errors = 0;
    int ptr_m [NS];

    always #2 clk = ~clk;

    lookahead_lock_tracker #(.NUM_STREAMS(NS), .PIPE_DELAY(DLY)) i_lookahead_lock_tracker (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_stream(iss_stream), .iss_lookahead(iss_lookahead),
        .iss_has_mem(iss_has_mem), .iss_wait_idx(iss_wait_idx),
        .mem_cpl_valid(mem_cpl_valid), .mem_cpl_stream(mem_cpl_stream), .mem_cpl_idx(mem_cpl_idx),
        .ready(ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge after the issue edge
    task automatic issue(input int s, input int la, input bit mem, output int widx);
        iss_valid = 1'b1; iss_stream = 2'(s); iss_lookahead = 3'(la); iss_has_mem = mem;
        #1;
        widx = int'(iss_wait_idx);
        chk("R2", "wait slot", widx, (ptr_m[s] + la + 1) % 8);
        ptr_m[s] = (ptr_m[s] + 1) % 8;
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic complete(input int s, input int idx);
        mem_cpl_valid = 1'b1; mem_cpl_stream = 2'(s); mem_cpl_idx = 3'(idx);
        @(negedge clk);
        mem_cpl_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "ready after reset", int'(ready), 4'hF);
        for (int s = 0; s < NS; s++) begin
            iss_stream = 2'(s); iss_lookahead = 3'd0;
            #1;
            chk("R1", "wait slot with pointer zero", int'(iss_wait_idx), 1);
        end
    endtask

    task automatic t_fixed_delay();
        int w;
        issue(0, 0, 1'b0, w);
        chk("R4", "stream0 stalls after lookahead 0", int'(ready[0]), 0);
        for (int i = 1; i < DLY; i++) begin
            @(negedge clk);
            chk("R5", "stream0 still waiting on pipe", int'(ready[0]), 0);
        end
        @(negedge clk);
        chk("R5", "stream0 free after pipe delay", int'(ready[0]), 1);
    endtask

    task automatic t_mem_completion();
        int w, w2;
        issue(1, 0, 1'b1, w);
        chk("R4", "stream1 stalls", int'(ready[1]), 0);
        issue(0, 7, 1'b0, w2);
        chk("R8", "stream1 unaffected by stream0", int'(ready[1]), 0);
        chk("R8", "stream3 unaffected by stream0", int'(ready[3]), 1);
        idle(DLY + 4);
        chk("R6", "memory op not freed by pipe", int'(ready[1]), 0);
        chk("R8", "stream0 drained", int'(ready[0]), 1);
        complete(1, w);
        chk("R6", "stream1 freed by response", int'(ready[1]), 1);
        chk("R8", "stream2 untouched by completion", int'(ready[2]), 1);
    endtask

    task automatic t_full_lookahead();
        int w [8];
        int n;
        for (int i = 0; i < 8; i++) begin
            issue(2, 7, 1'b1, n);
            w[i] = n;
            if (i < 7) chk("R4", "lookahead 7 keeps stream ready", int'(ready[2]), 1);
        end
        chk("R4", "stall after 8 in flight", int'(ready[2]), 0);
        complete(2, w[0]);
        chk("R3", "oldest completion frees pointer lock", int'(ready[2]), 1);
        for (int i = 1; i < 8; i++) complete(2, w[i]);
        chk("R3", "ready after draining ring", int'(ready[2]), 1);
        iss_stream = 2'd2; iss_lookahead = 3'd0;
        #1;
        chk("R3", "pointer wrapped to zero", int'(iss_wait_idx), 1);
    endtask

    task automatic t_two_predecessors();
        int wa, wb;
        issue(3, 1, 1'b1, wa);
        chk("R4", "lookahead 1 leaves stream ready", int'(ready[3]), 1);
        issue(3, 0, 1'b1, wb);
        chk("R9", "both target one lock", wa, wb);
        chk("R9", "blocked on two", int'(ready[3]), 0);
        complete(3, wa);
        chk("R9", "still blocked on one", int'(ready[3]), 0);
        complete(3, wb);
        chk("R9", "free after both", int'(ready[3]), 1);
    endtask

    task automatic t_same_cycle();
        int wx, wy;
        issue(1, 1, 1'b1, wx);
        // issue Y (targets the same lock) while X completes on that lock
        iss_valid = 1'b1; iss_stream = 2'd1; iss_lookahead = 3'd0; iss_has_mem = 1'b1;
        mem_cpl_valid = 1'b1; mem_cpl_stream = 2'd1; mem_cpl_idx = 3'(wx);
        #1;
        wy = int'(iss_wait_idx);
        chk("R7", "same target lock", wy, wx);
        ptr_m[1] = (ptr_m[1] + 1) % 8;
        @(negedge clk);
        iss_valid = 1'b0; mem_cpl_valid = 1'b0;
        chk("R7", "net zero keeps Y's dependant blocked", int'(ready[1]), 0);
        complete(1, wy);
        chk("R7", "one more completion frees it", int'(ready[1]), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) ptr_m[s] = 0;
        rst_n = 1'b0; iss_valid = 1'b0; iss_stream = '0; iss_lookahead = '0; iss_has_mem = 1'b0;
        mem_cpl_valid = 1'b0; mem_cpl_stream = '0; mem_cpl_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_delay();
        idle(DLY + 2);
        t_mem_completion();
        idle(DLY + 2);
        t_full_lookahead();
        t_two_predecessors();
        t_same_cycle();
        idle(2);
        summary();
        $finish;
    end
endmodule